// File: doc/BRIEF.md
# PCI Configuration Access Sequencer

This block carries out a single PCI configuration read or write for a host that only reaches the PCI bus through a local-bus address translator with three windows. The translator matches an address against its windows in ascending order and uses the first window that hits. The sequencer relies on that order. It first enlarges window 0 from 256 MB to 512 MB, so that window 0 covers the range that window 1 normally serves. Window 1 is then free, and the sequencer points it at configuration space. It performs the configuration access, then puts window 1 back to prefetchable memory before it shrinks window 0 again.

The host gives a bus number, a device/function number, a register offset, an access size in bytes and the write data, and raises a request strobe. The sequencer builds the configuration address and the window 1 map value:

- **Bus 0 (type 0):** the device select is one-hot. It goes in the address for low slot numbers and in the map value for high slot numbers.
- **Other buses (type 1):** the bus and device/function numbers are packed into the address.

The sequencer sends six window-register writes and one or two data accesses through two acknowledged ports. It returns the read data together with a one-cycle done pulse, and an error flag when the request was rejected.

Top module: `cfg_access_seq`

## Requirements
- R1: After reset, busy, done, err, regWrEn and accEn are all low.
- R2: An accepted request first issues three register writes, in this order: sel 0 (window 0 base) = 0x4000_6001, covering 512 MB; then sel 1 (window 1 base) = 0x6100_1001, covering 16 MB; then sel 2 (window 1 map) = the configuration map value. Window base words use this layout: bits 31:20 hold the local address, bits 15:12 hold the size code (1 = 16 MB, 5 = 256 MB, 6 = 512 MB), bit 1 is prefetch and bit 0 is enable.
- R3: After the data access, the close writes follow in this order: sel 1 = 0x5000_5003 (256 MB, prefetchable), then sel 2 = 0x0000_1006 (bus address 0x1000_0000 in map bits 15:4, memory-multiple type 3'b011 in bits 3:1), then sel 0 = 0x4000_5001.
- R4: For bus 0 and a slot (devfn bits 7:3) of 12 or less, the access address is 0x6100_0000 + (func << 8) + (1 << (slot+11)) + offset, and the map value is 0xA (configuration type 3'b101 in bits 3:1, bit 0 clear).
- R5: For bus 0 and a slot above 12, no device bit is placed in the address, and bit (slot-5) of the map value is set on top of 0xA.
- R6: For a nonzero bus, the access address is 0x6100_0000 + (bus << 16) + (devfn << 8) + offset, and the map value is 0xB (bit 0 enables pass-through of the low address bits).
- R7: An offset, bus or devfn above 255 aborts the request. Done and err pulse together one cycle later, and no register write or data access is issued.
- R8: Every configuration write is followed at once by a read of the same address and size before the close writes begin.
- R9: A size of 1 or 2 is used as given; any other size becomes 4. rdData returns the last read's data zero-extended to that size. Write data is masked to the size in the same way.
- R10: Every register write and data access is held stable until its acknowledge. Busy is high from acceptance until the final close write is acknowledged. Done pulses for one cycle on the next cycle, with busy low.
- R11: A request presented while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken only when idle |
| reqWrite | input | 1 | 1 = configuration write |
| reqBus | input | IDX_W | Bus number |
| reqDevfn | input | IDX_W | Device (7:3) and function (2:0) number |
| reqOffset | input | IDX_W | Register offset |
| reqSize | input | 3 | Access size in bytes |
| reqWdata | input | 32 | Write data |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Request rejected, set together with done |
| rdData | output | 32 | Data from the last read |
| regWrEn | output | 1 | Window register write request |
| regSel | output | 2 | 0 = window 0 base, 1 = window 1 base, 2 = window 1 map |
| regWrData | output | 32 | Register value |
| regAck | input | 1 | Register write acknowledge |
| accEn | output | 1 | Data access request |
| accWrite | output | 1 | Data access direction |
| accAddr | output | 32 | Translated configuration address |
| accSize | output | 3 | Normalised byte count (1, 2 or 4) |
| accWdata | output | 32 | Masked write data |
| accRdata | input | 32 | Read data, right-justified |
| accAck | input | 1 | Data access acknowledge |

## Verification
Busy is due on the first cycle after the accepting edge, because one state register sits between the request and the output. The bench samples busy on the falling edge that follows. Every later step moves on one cycle after its acknowledge, so the bench waits for done rather than counting edges. Once done is seen, the bench checks that it has gone low one cycle later. Register writes and data accesses are recorded on the edge where enable and acknowledge are both high, so each step is logged exactly once. A rejected request shows done and err on the first cycle after its edge, and the bench then waits several more cycles to confirm that the port logs are still empty.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;
  typedef enum logic [1:0] {
    SEL_BASE0 = 2'd0,
    SEL_BASE1 = 2'd1,
    SEL_MAP1  = 2'd2
  } regsel_e;

  typedef enum logic [2:0] {
    STEP_OPEN_B0,
    STEP_OPEN_B1,
    STEP_OPEN_M1,
    STEP_CLOSE_B1,
    STEP_CLOSE_M1,
    STEP_CLOSE_B0
  } step_e;

  typedef struct packed {
    logic  loadReq;
    logic  capRead;
    step_e step;
  } ctl_s;

  localparam logic [3:0] SZ_16M       = 4'h1;
  localparam logic [3:0] SZ_256M      = 4'h5;
  localparam logic [3:0] SZ_512M      = 4'h6;
  localparam logic [2:0] MAPT_CFG     = 3'b101;
  localparam logic [2:0] MAPT_MEMMULT = 3'b011;

  function automatic logic [31:0] baseWord(logic [31:0] a, logic [3:0] sz, logic pf);
    return {a[31:20], 4'b0, sz, 10'b0, pf, 1'b1};
  endfunction

  function automatic logic [31:0] laneMask(logic [2:0] s);
    case (s)
      3'd1:    return 32'h0000_00FF;
      3'd2:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/cfgseq_ctrl.sv
module cfgseq_ctrl
  import cfgseq_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic reqValid,
  input  logic reqWrite,
  input  logic reqBad,
  input  logic regAck,
  input  logic accAck,
  output logic regWrEn,
  output logic accEn,
  output logic accWrite,
  output logic busy,
  output logic done,
  output logic err,
  output ctl_s ctl
);
  typedef enum logic [3:0] {
    S_IDLE, S_OB0, S_OB1, S_OM1, S_WR, S_RD, S_CB1, S_CM1, S_CB0
  } state_e;

  state_e st, nxt;
  logic   wrQ;
  logic   badReq;

  assign badReq = (st == S_IDLE) && reqValid && reqBad;

  always_comb begin
    nxt = st;
    case (st)
      S_IDLE: if (reqValid && !reqBad) nxt = S_OB0;
      S_OB0:  if (regAck) nxt = S_OB1;
      S_OB1:  if (regAck) nxt = S_OM1;
      S_OM1:  if (regAck) nxt = wrQ ? S_WR : S_RD;
      S_WR:   if (accAck) nxt = S_RD;
      S_RD:   if (accAck) nxt = S_CB1;
      S_CB1:  if (regAck) nxt = S_CM1;
      S_CM1:  if (regAck) nxt = S_CB0;
      S_CB0:  if (regAck) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_comb begin
    ctl.loadReq = (st == S_IDLE) && reqValid && !reqBad;
    ctl.capRead = (st == S_RD) && accAck;
    case (st)
      S_OB1:   ctl.step = STEP_OPEN_B1;
      S_OM1:   ctl.step = STEP_OPEN_M1;
      S_CB1:   ctl.step = STEP_CLOSE_B1;
      S_CM1:   ctl.step = STEP_CLOSE_M1;
      S_CB0:   ctl.step = STEP_CLOSE_B0;
      default: ctl.step = STEP_OPEN_B0;
    endcase
  end

  assign regWrEn  = (st == S_OB0) || (st == S_OB1) || (st == S_OM1) ||
                    (st == S_CB1) || (st == S_CM1) || (st == S_CB0);
  assign accEn    = (st == S_WR) || (st == S_RD);
  assign accWrite = (st == S_WR);
  assign busy     = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st   <= S_IDLE;
      wrQ  <= 1'b0;
      done <= 1'b0;
      err  <= 1'b0;
    end else begin
      st   <= nxt;
      if (ctl.loadReq) wrQ <= reqWrite;
      done <= ((st == S_CB0) && regAck) || badReq;
      err  <= badReq;
    end
  end
endmodule

// File: rtl/cfgseq_dp.sv
module cfgseq_dp
  import cfgseq_pkg::*;
#(
  parameter int          IDX_W      = 9,
  parameter logic [31:0] MEM_BASE   = 32'h4000_0000,
  parameter logic [31:0] CFG_BASE   = 32'h6100_0000,
  parameter logic [31:0] PREMEM_BUS = 32'h1000_0000,
  parameter int          SLOT_SPLIT = 12
)(
  input  logic             clk,
  input  logic             rstN,
  input  ctl_s             ctl,
  input  logic [IDX_W-1:0] reqBus,
  input  logic [IDX_W-1:0] reqDevfn,
  input  logic [IDX_W-1:0] reqOffset,
  input  logic [2:0]       reqSize,
  input  logic [31:0]      reqWdata,
  input  logic [31:0]      accRdata,
  output logic             reqBad,
  output logic [1:0]       regSel,
  output logic [31:0]      regWrData,
  output logic [31:0]      accAddr,
  output logic [2:0]       accSize,
  output logic [31:0]      accWdata,
  output logic [31:0]      rdData
);
  localparam int          HI       = IDX_W - 1;
  localparam logic [31:0] PREF_LOC = MEM_BASE + 32'h1000_0000;

  logic [4:0]  slot;
  logic [2:0]  func;
  logic [31:0] oneHot, offAddr, mapVal, newAddr;
  logic [2:0]  newSize;
  logic [31:0] mapQ, wdataQ;

  assign slot   = reqDevfn[7:3];
  assign func   = reqDevfn[2:0];
  assign oneHot = 32'd1 << slot;
  assign reqBad = (|reqBus[HI:8]) || (|reqDevfn[HI:8]) || (|reqOffset[HI:8]);

  always_comb begin
    if (reqBus[7:0] == 8'd0) begin
      offAddr = {21'b0, func, 8'b0};
      mapVal  = {28'b0, MAPT_CFG, 1'b0};
      if (int'(slot) > SLOT_SPLIT) mapVal  = mapVal | (oneHot >> 5);
      else                         offAddr = offAddr | (oneHot << 11);
    end else begin
      offAddr = {8'b0, reqBus[7:0], reqDevfn[7:0], 8'b0};
      mapVal  = {28'b0, MAPT_CFG, 1'b1};
    end
    newAddr = CFG_BASE + offAddr + {24'b0, reqOffset[7:0]};
    newSize = (reqSize == 3'd1) ? 3'd1 : (reqSize == 3'd2) ? 3'd2 : 3'd4;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accAddr <= '0;
      accSize <= 3'd4;
      mapQ    <= '0;
      wdataQ  <= '0;
      rdData  <= '0;
    end else begin
      if (ctl.loadReq) begin
        accAddr <= newAddr;
        accSize <= newSize;
        mapQ    <= mapVal;
        wdataQ  <= reqWdata & laneMask(newSize);
      end
      if (ctl.capRead) rdData <= accRdata & laneMask(accSize);
    end
  end

  assign accWdata = wdataQ;

  always_comb begin
    case (ctl.step)
      STEP_OPEN_B1: begin
        regSel = SEL_BASE1; regWrData = baseWord(CFG_BASE, SZ_16M, 1'b0);
      end
      STEP_OPEN_M1: begin
        regSel = SEL_MAP1;  regWrData = mapQ;
      end
      STEP_CLOSE_B1: begin
        regSel = SEL_BASE1; regWrData = baseWord(PREF_LOC, SZ_256M, 1'b1);
      end
      STEP_CLOSE_M1: begin
        regSel = SEL_MAP1;  regWrData = {16'b0, PREMEM_BUS[31:20], MAPT_MEMMULT, 1'b0};
      end
      STEP_CLOSE_B0: begin
        regSel = SEL_BASE0; regWrData = baseWord(MEM_BASE, SZ_256M, 1'b0);
      end
      default: begin
        regSel = SEL_BASE0; regWrData = baseWord(MEM_BASE, SZ_512M, 1'b0);
      end
    endcase
  end
endmodule

// File: rtl/cfg_access_seq.sv
module cfg_access_seq
  import cfgseq_pkg::*;
#(
  parameter int          IDX_W      = 9,
  parameter logic [31:0] MEM_BASE   = 32'h4000_0000,
  parameter logic [31:0] CFG_BASE   = 32'h6100_0000,
  parameter logic [31:0] PREMEM_BUS = 32'h1000_0000,
  parameter int          SLOT_SPLIT = 12
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [IDX_W-1:0] reqBus,
  input  logic [IDX_W-1:0] reqDevfn,
  input  logic [IDX_W-1:0] reqOffset,
  input  logic [2:0]       reqSize,
  input  logic [31:0]      reqWdata,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [31:0]      rdData,
  output logic             regWrEn,
  output logic [1:0]       regSel,
  output logic [31:0]      regWrData,
  input  logic             regAck,
  output logic             accEn,
  output logic             accWrite,
  output logic [31:0]      accAddr,
  output logic [2:0]       accSize,
  output logic [31:0]      accWdata,
  input  logic [31:0]      accRdata,
  input  logic             accAck
);
  ctl_s ctl;
  logic reqBad;

  cfgseq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqBad(reqBad), .regAck(regAck), .accAck(accAck), .regWrEn(regWrEn),
    .accEn(accEn), .accWrite(accWrite), .busy(busy), .done(done), .err(err),
    .ctl(ctl)
  );

  cfgseq_dp #(
    .IDX_W(IDX_W), .MEM_BASE(MEM_BASE), .CFG_BASE(CFG_BASE),
    .PREMEM_BUS(PREMEM_BUS), .SLOT_SPLIT(SLOT_SPLIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqBus(reqBus), .reqDevfn(reqDevfn),
    .reqOffset(reqOffset), .reqSize(reqSize), .reqWdata(reqWdata),
    .accRdata(accRdata), .reqBad(reqBad), .regSel(regSel),
    .regWrData(regWrData), .accAddr(accAddr), .accSize(accSize),
    .accWdata(accWdata), .rdData(rdData)
  );
endmodule

// File: rtl/cfg_access_seq_chk.sv
module cfg_access_seq_chk #(
  parameter int IDX_W = 9
)(
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic [IDX_W-1:0] reqBus,
  input logic             busy,
  input logic             done,
  input logic             err,
  input logic             regWrEn,
  input logic [1:0]       regSel,
  input logic [31:0]      regWrData,
  input logic             regAck,
  input logic             accEn,
  input logic             accWrite,
  input logic [31:0]      accAddr,
  input logic [2:0]       accSize,
  input logic             accAck
);
  p_ports_exclusive_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && accEn));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!regWrEn && !accEn));

  p_reg_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn && !regAck |=> regWrEn && $stable(regSel) && $stable(regWrData));

  p_acc_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    accEn && !accAck |=> accEn && $stable(accAddr) && $stable(accWrite));

  p_flush_read_r8: assert property (@(posedge clk) disable iff (!rstN)
    accEn && accWrite && accAck |=> accEn && !accWrite && $stable(accAddr) && $stable(accSize));

  p_open_order_r2: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn && regAck && regSel == 2'd0 && regWrData[15:12] == 4'h6
    |=> regWrEn && regSel == 2'd1);

  p_close_last_r3: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn && regAck && regSel == 2'd0 && regWrData[15:12] == 4'h5
    |=> done && !busy);

  p_err_with_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    err |-> done);

  p_bad_abort_r7: assert property (@(posedge clk) disable iff (!rstN)
    !busy && reqValid && (|reqBus[IDX_W-1:8]) |=> err && !busy);

  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
endmodule

bind cfg_access_seq cfg_access_seq_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqBus(reqBus),
  .busy(busy), .done(done), .err(err), .regWrEn(regWrEn), .regSel(regSel),
  .regWrData(regWrData), .regAck(regAck), .accEn(accEn), .accWrite(accWrite),
  .accAddr(accAddr), .accSize(accSize), .accAck(accAck)
);

// File: tb/sim_cfg_access_seq.sv
module sim_cfg_access_seq;
  localparam logic [31:0] RD_KEY = 32'h5A5A_3C3C;

  typedef struct packed {
    logic [8:0]  bus;
    logic [8:0]  devfn;
    logic [8:0]  off;
    logic [2:0]  size;
    logic        wr;
    logic [31:0] wdata;
    logic [31:0] expAddr;
    logic [31:0] expMap;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{9'h000, 9'h01A, 9'h010, 3'd4, 1'b0, 32'h0,         32'h6100_4210, 32'h0000_000A},
    '{9'h000, 9'h062, 9'h004, 3'd2, 1'b0, 32'h0,         32'h6180_0204, 32'h0000_000A},
    '{9'h000, 9'h069, 9'h03C, 3'd1, 1'b0, 32'h0,         32'h6100_013C, 32'h0000_010A},
    '{9'h000, 9'h0FF, 9'h0FF, 3'd3, 1'b0, 32'h0,         32'h6100_07FF, 32'h0400_000A},
    '{9'h005, 9'h04B, 9'h008, 3'd4, 1'b1, 32'hDEAD_BEEF, 32'h6105_4B08, 32'h0000_000B},
    '{9'h0FF, 9'h000, 9'h0FF, 3'd1, 1'b1, 32'h1234_56C7, 32'h61FF_00FF, 32'h0000_000B},
    '{9'h001, 9'h008, 9'h002, 3'd2, 1'b0, 32'h0,         32'h6101_0802, 32'h0000_000B}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [8:0] reqBus = '0, reqDevfn = '0, reqOffset = '0;
  logic [2:0] reqSize = 3'd4;
  logic [31:0] reqWdata = '0;
  logic busy, done, err, regWrEn, accEn, accWrite;
  logic [1:0] regSel;
  logic [31:0] rdData, regWrData, accAddr, accWdata, accRdata;
  logic [2:0] accSize;
  logic regAck = 1'b0, accAck = 1'b0;
  logic clrLog = 1'b0;

  int regCount = 0, accCount = 0;
  logic [1:0]  logSel  [8];
  logic [31:0] logData [8];
  logic [31:0] aAddr [4];
  logic [2:0]  aSize [4];
  logic        aWr   [4];
  logic [31:0] aWdat [4];

  int nChecks = 0, nFails = 0;

  always #5 clk = ~clk;

  assign accRdata = accAddr ^ RD_KEY;

  cfg_access_seq u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqBus(reqBus), .reqDevfn(reqDevfn), .reqOffset(reqOffset),
    .reqSize(reqSize), .reqWdata(reqWdata), .busy(busy), .done(done),
    .err(err), .rdData(rdData), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .regAck(regAck), .accEn(accEn),
    .accWrite(accWrite), .accAddr(accAddr), .accSize(accSize),
    .accWdata(accWdata), .accRdata(accRdata), .accAck(accAck)
  );

  // Responder: acknowledges one cycle after a request and logs completed steps.
  always @(posedge clk) begin
    regAck <= regWrEn && !regAck;
    accAck <= accEn && !accAck;
    if (clrLog) begin
      regCount <= 0;
      accCount <= 0;
    end else begin
      if (regWrEn && regAck && regCount < 8) begin
        logSel[regCount]  <= regSel;
        logData[regCount] <= regWrData;
        regCount <= regCount + 1;
      end
      if (accEn && accAck && accCount < 4) begin
        aAddr[accCount] <= accAddr;
        aSize[accCount] <= accSize;
        aWr[accCount]   <= accWrite;
        aWdat[accCount] <= accWdata;
        accCount <= accCount + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] normSize(logic [2:0] s);
    return (s == 3'd1) ? 3'd1 : (s == 3'd2) ? 3'd2 : 3'd4;
  endfunction

  function automatic logic [31:0] mask(logic [2:0] s);
    return (s == 3'd1) ? 32'hFF : (s == 3'd2) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  task automatic clearLogs();
    @(negedge clk) clrLog = 1'b1;
    @(negedge clk) clrLog = 1'b0;
  endtask

  task automatic issue(input logic [8:0] b, input logic [8:0] d, input logic [8:0] o,
                       input logic [2:0] s, input logic w, input logic [31:0] wd);
    reqBus = b; reqDevfn = d; reqOffset = o; reqSize = s; reqWrite = w; reqWdata = wd;
    reqValid = 1'b1;
    @(negedge clk) reqValid = 1'b0;
  endtask

  task automatic waitDone(output bit seen);
    seen = 0;
    for (int i = 0; i < 200; i++) begin
      if (done) begin seen = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic finishReport();
    $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    #2_000_000;
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
    finishReport();
  end

  initial begin
    bit seen;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !err && !regWrEn && !accEn, "R1 reset outputs",
        {27'b0, busy, done, err, regWrEn, accEn}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      clearLogs();
      issue(VECS[v].bus, VECS[v].devfn, VECS[v].off, VECS[v].size, VECS[v].wr, VECS[v].wdata);
      chk(busy, "R10 busy after accept", {31'b0, busy}, 32'h1);
      waitDone(seen);
      chk(seen && !err, "R10 done without err", {30'b0, seen, err}, 32'h2);
      chk(regCount == 6, "R2/R3 register write count", regCount, 6);
      chk(logSel[0] == 2'd0 && logData[0] == 32'h4000_6001, "R2 open window 0", logData[0], 32'h4000_6001);
      chk(logSel[1] == 2'd1 && logData[1] == 32'h6100_1001, "R2 open window 1", logData[1], 32'h6100_1001);
      chk(logSel[2] == 2'd2 && logData[2] == VECS[v].expMap, "R2 R4/R5/R6 map value", logData[2], VECS[v].expMap);
      chk(logSel[3] == 2'd1 && logData[3] == 32'h5000_5003, "R3 restore window 1", logData[3], 32'h5000_5003);
      chk(logSel[4] == 2'd2 && logData[4] == 32'h0000_1006, "R3 restore map 1", logData[4], 32'h0000_1006);
      chk(logSel[5] == 2'd0 && logData[5] == 32'h4000_5001, "R3 shrink window 0", logData[5], 32'h4000_5001);
      chk(accCount == (VECS[v].wr ? 2 : 1), "R8 access count", accCount, VECS[v].wr ? 2 : 1);
      chk(aAddr[0] == VECS[v].expAddr, "R4/R5/R6/R7 access address", aAddr[0], VECS[v].expAddr);
      chk(aSize[0] == normSize(VECS[v].size), "R9 access size", {29'b0, aSize[0]}, {29'b0, normSize(VECS[v].size)});
      chk(aWr[0] == VECS[v].wr, "R8 first access direction", {31'b0, aWr[0]}, {31'b0, VECS[v].wr});
      if (VECS[v].wr) begin
        chk(aWdat[0] == (VECS[v].wdata & mask(VECS[v].size)), "R9 write data masked",
            aWdat[0], VECS[v].wdata & mask(VECS[v].size));
        chk(!aWr[1] && aAddr[1] == aAddr[0] && aSize[1] == aSize[0], "R8 flush read",
            aAddr[1], aAddr[0]);
      end
      chk(rdData == ((VECS[v].expAddr ^ RD_KEY) & mask(VECS[v].size)), "R9 read data",
          rdData, (VECS[v].expAddr ^ RD_KEY) & mask(VECS[v].size));
      @(negedge clk);
      chk(!done && !busy, "R10 done is one pulse", {30'b0, done, busy}, 32'h0);
    end

    // R7 out-of-range offset, bus, devfn
    for (int k = 0; k < 3; k++) begin
      clearLogs();
      issue(k == 1 ? 9'h100 : 9'h0, k == 2 ? 9'h1F0 : 9'h08, k == 0 ? 9'h100 : 9'h0, 3'd4, 1'b1, 32'h1);
      chk(done && err && !busy, "R7 abort flags", {29'b0, done, err, busy}, 32'h6);
      repeat (5) @(negedge clk);
      chk(regCount == 0 && accCount == 0, "R7 no port activity", regCount + accCount, 0);
    end

    // R11 requests while busy are ignored
    clearLogs();
    issue(9'h0, 9'h01A, 9'h010, 3'd4, 1'b0, 32'h0);
    @(negedge clk);
    reqBus = 9'h1FF; reqOffset = 9'h1FF; reqValid = 1'b1;
    repeat (3) @(negedge clk);
    chk(!done && !err && busy, "R11 busy request not taken", {29'b0, done, err, busy}, 32'h1);
    reqValid = 1'b0;
    waitDone(seen);
    chk(seen && !err && regCount == 6 && accCount == 1, "R11 single transaction", regCount, 6);
    chk(aAddr[0] == 32'h6100_4210, "R11 original request kept", aAddr[0], 32'h6100_4210);

    finishReport();
  end
endmodule